// File: doc/BRIEF.md
# Serial Bus Mode Lock Detector

This block decides which of two serial bus front ends owns the shared pins. Out of power-on reset it drives the two-wire mode, but that choice is only a default and is not latched. The block watches the active-low chip-select pin. When it counts a set number of low-to-high transitions (three by default) it switches to the four-wire mode and latches that choice. From then on the choice holds until the power-on reset input is asserted again.

The chip-select pin is synchronized into the system clock domain before its rising edges are counted. A saturating counter tracks the pulses seen. A one-way latch holds the lock, and only the power-on reset clears the counter or the latch. The software reset input has no effect on either. It clears only the read-data register. Software reads the lock through a read-only status location at address 7Fh. Bit 0 of that location is the lock and all other bits read zero. Writes to the block are accepted and discarded. The protocol engines for both buses sit outside this block and are steered by `four_wire_sel`.

Top module: `bus_mode_lock`

## Requirements
- R1: After the power-on reset is released, `four_wire_sel` is 0 and a read of address 7Fh returns 00h.
- R2: A chip-select rising edge applied between clock edges is counted through a two-stage synchronizer. On the third counted rising edge, `four_wire_sel` goes to 1 on the third clock edge after the pin change, and not earlier.
- R3: With fewer than three rising edges seen since power-on reset, `four_wire_sel` stays 0. A chip-select held static, either high or low, never selects the four-wire mode.
- R4: Once `four_wire_sel` is 1 it stays 1 through any later chip-select activity, including further pulses.
- R5: The software reset clears neither the lock nor a partial pulse count. Two pulses, then a software reset, then one pulse still lock. The software reset clears `reg_rd_data` to 00h on the next clock edge.
- R6: A read with `reg_rd_en` high loads `reg_rd_data` on the next clock edge. At address 7Fh the value is 00h when unlocked and 01h when locked, with bit 0 as the lock. Any other address returns 00h.
- R7: Writes (`reg_wr_en` high), including writes to 7Fh, change neither the pulse count nor the lock, and do not change `four_wire_sel`.
- R8: Asserting the power-on reset clears the lock. After release the block is back in two-wire mode and needs three new rising edges to lock again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| cs_n_pin | input | 1 | Raw chip-select pin, asynchronous |
| reg_addr | input | 8 | Register access address |
| reg_rd_en | input | 1 | Read strobe |
| reg_wr_en | input | 1 | Write strobe (data discarded) |
| reg_rd_data | output | 8 | Registered read data |
| four_wire_sel | output | 1 | 1 selects the four-wire bus mode |

## Verification
A chip-select rise takes two clock edges to leave the synchronizer, and the counter registers the lock on the third. The bench therefore samples `four_wire_sel` on the falling edge after the second clock edge, where it expects 0, and again after the third, where it expects 1. Read data is due on the first clock edge after the read strobe. The clearing effect of the software reset is also due one edge after the reset. All inputs change on falling edges, so every check knows how many rising edges have passed since its stimulus. Each pulse holds the pin low for five cycles, so the synchronizer always sees the low level before the next rise.

// File: rtl/bml_pkg.sv
package bml_pkg;

   typedef enum logic {
      MODE_TWO_WIRE  = 1'b0,
      MODE_FOUR_WIRE = 1'b1
   } bus_mode_e;

   localparam int LOCK_BIT_POS = 0;

   function automatic bus_mode_e mode_of(input logic locked);
      return locked ? MODE_FOUR_WIRE : MODE_TWO_WIRE;
   endfunction

endpackage

// File: rtl/bml_cs_sync.sv
module bml_cs_sync #(
   parameter int STAGES     = 2,
   parameter bit IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic por_n,
   input  logic cs_raw,
   output logic cs_rise
);

   if (STAGES < 1) begin : g_bad_stages
      $error("bml_cs_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sync_q;
   logic [STAGES-1:0] sync_d;
   logic              level;
   logic              prev_q;

   if (STAGES == 1) begin : g_single
      assign sync_d = cs_raw;
   end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], cs_raw};
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sync_q <= {STAGES{IDLE_LEVEL}};
         prev_q <= IDLE_LEVEL;
      end else begin
         sync_q <= sync_d;
         prev_q <= level;
      end
   end

   assign level   = sync_q[STAGES-1];
   assign cs_rise = level & ~prev_q;

   // R2: a counted edge is a synchronized low-to-high step
   p_rise_is_step_r2: assert property (@(posedge clk) disable iff (!por_n)
      cs_rise |-> (level && !$past(level)));

endmodule

// File: rtl/bml_pulse_lock.sv
module bml_pulse_lock #(
   parameter int PULSES = 3
) (
   input  logic clk,
   input  logic por_n,
   input  logic cs_rise,
   output logic locked
);

   if (PULSES < 1) begin : g_bad_pulses
      $error("bml_pulse_lock: PULSES must be at least 1");
   end

   logic lock_q;

   if (PULSES == 1) begin : g_direct
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) lock_q <= 1'b0;
         else        lock_q <= lock_q | cs_rise;
      end
   end else begin : g_count
      localparam int CW = $clog2(PULSES + 1);
      localparam logic [CW-1:0] FULL = CW'(PULSES);
      localparam logic [CW-1:0] LAST = CW'(PULSES - 1);

      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
         end else begin
            if (cs_rise && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
            if (cs_rise && cnt_q == LAST) lock_q <= 1'b1;
         end
      end

      // R3: the count moves only on a counted edge
      p_count_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
         !cs_rise |=> $stable(cnt_q));
      // R4: count never exceeds its saturation value
      p_count_sat_r4: assert property (@(posedge clk) disable iff (!por_n)
         (cnt_q == FULL) |=> (cnt_q == FULL));
   end

   assign locked = lock_q;

   // R4: lock is one-way
   p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!por_n)
      locked |=> locked);
   // R2: lock only rises right after a counted edge
   p_lock_cause_r2: assert property (@(posedge clk) disable iff (!por_n)
      $rose(locked) |-> $past(cs_rise));

endmodule

// File: rtl/bml_status_port.sv
module bml_status_port #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int STATUS_ADDR = 'h7F
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sw_rst,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              locked,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W <= bml_pkg::LOCK_BIT_POS) begin : g_bad_data
      $error("bml_status_port: DATA_W too narrow for the lock bit");
   end
   if (STATUS_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("bml_status_port: STATUS_ADDR does not fit in ADDR_W");
   end

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);

   logic              hit;
   logic [DATA_W-1:0] status_w;
   logic [DATA_W-1:0] rd_q;

   assign hit = (addr == STAT_A);

   always_comb begin
      status_w = '0;
      status_w[bml_pkg::LOCK_BIT_POS] = locked;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      rd_q <= '0;
      else if (sw_rst) rd_q <= '0;
      else if (rd_en)  rd_q <= hit ? status_w : '0;
   end

   assign rd_data = rd_q;

   // R6: status read returns the lock in its bit, zero elsewhere
   p_status_read_r6: assert property (@(posedge clk) disable iff (!por_n)
      (rd_en && hit && !sw_rst) |=>
         (rd_data[bml_pkg::LOCK_BIT_POS] == $past(locked)) &&
         ($countones(rd_data) == $past(locked)));
   // R6: other addresses read zero
   p_other_read_r6: assert property (@(posedge clk) disable iff (!por_n)
      (rd_en && !hit && !sw_rst) |=> (rd_data == '0));
   // R5: software reset clears read data
   p_sw_clear_r5: assert property (@(posedge clk) disable iff (!por_n)
      sw_rst |=> (rd_data == '0));

endmodule

// File: rtl/bus_mode_lock.sv
module bus_mode_lock #(
   parameter int SYNC_STAGES = 2,
   parameter int LOCK_PULSES = 3,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int STATUS_ADDR = 'h7F
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sw_rst,
   input  logic              cs_n_pin,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd_en,
   input  logic              reg_wr_en,
   output logic [DATA_W-1:0] reg_rd_data,
   output logic              four_wire_sel
);

   logic cs_rise_w;
   logic locked_w;

   bml_cs_sync #(
      .STAGES     (SYNC_STAGES),
      .IDLE_LEVEL (1'b1)
   ) sync_i (
      .clk     (clk),
      .por_n   (por_n),
      .cs_raw  (cs_n_pin),
      .cs_rise (cs_rise_w)
   );

   bml_pulse_lock #(
      .PULSES (LOCK_PULSES)
   ) lock_i (
      .clk     (clk),
      .por_n   (por_n),
      .cs_rise (cs_rise_w),
      .locked  (locked_w)
   );

   bml_status_port #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .STATUS_ADDR (STATUS_ADDR)
   ) stat_i (
      .clk     (clk),
      .por_n   (por_n),
      .sw_rst  (sw_rst),
      .rd_en   (reg_rd_en),
      .addr    (reg_addr),
      .locked  (locked_w),
      .rd_data (reg_rd_data)
   );

   assign four_wire_sel = (bml_pkg::mode_of(locked_w) == bml_pkg::MODE_FOUR_WIRE);

   // R7: a write with no concurrent counted edge leaves the mode alone
   p_write_ignored_r7: assert property (@(posedge clk) disable iff (!por_n)
      (reg_wr_en && !cs_rise_w) |=> $stable(four_wire_sel));
   // R5: software reset alone never changes the mode
   p_sw_keeps_mode_r5: assert property (@(posedge clk) disable iff (!por_n)
      (sw_rst && !cs_rise_w) |=> $stable(four_wire_sel));

endmodule

// File: tb/bus_mode_lock_tb_top.sv
module bus_mode_lock_tb_top;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sw_rst = 1'b0;
   logic       cs_n_pin = 1'b1;
   logic [7:0] reg_addr = 8'h00;
   logic       reg_rd_en = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_rd_data;
   logic       four_wire_sel;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bus_mode_lock dut_i (
      .clk           (clk),
      .por_n         (por_n),
      .sw_rst        (sw_rst),
      .cs_n_pin      (cs_n_pin),
      .reg_addr      (reg_addr),
      .reg_rd_en     (reg_rd_en),
      .reg_wr_en     (reg_wr_en),
      .reg_rd_data   (reg_rd_data),
      .four_wire_sel (four_wire_sel)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_por();
      @(negedge clk);
      por_n = 1'b0; cs_n_pin = 1'b1; sw_rst = 1'b0;
      reg_rd_en = 1'b0; reg_wr_en = 1'b0;
      cycles(3);
      por_n = 1'b1;
      cycles(2);
   endtask

   task automatic pulse();
      cs_n_pin = 1'b0; cycles(5);
      cs_n_pin = 1'b1; cycles(5);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a; reg_rd_en = 1'b1;
      cycles(1);
      reg_rd_en = 1'b0;
      d = reg_rd_data;
   endtask

   task automatic wr(input logic [7:0] a);
      reg_addr = a; reg_wr_en = 1'b1;
      cycles(1);
      reg_wr_en = 1'b0;
   endtask

   task automatic soft_reset();
      sw_rst = 1'b1; cycles(1); sw_rst = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_por();
      check("R1 mode after power-on", {7'b0, four_wire_sel}, 8'h00);
      rd(8'h7F, d);
      check("R1 status after power-on", d, 8'h00);
   endtask

   task automatic t_static();
      do_por();
      cycles(30);
      check("R3 static high", {7'b0, four_wire_sel}, 8'h00);
      cs_n_pin = 1'b0; cycles(30);
      check("R3 static low", {7'b0, four_wire_sel}, 8'h00);
   endtask

   task automatic t_lock_timing();
      logic [7:0] d;
      do_por();
      pulse(); pulse();
      check("R3 two pulses no lock", {7'b0, four_wire_sel}, 8'h00);
      rd(8'h7F, d);
      check("R6 status unlocked", d, 8'h00);
      cs_n_pin = 1'b0; cycles(5);
      cs_n_pin = 1'b1; cycles(2);
      check("R2 not yet after two edges", {7'b0, four_wire_sel}, 8'h00);
      cycles(1);
      check("R2 lock on third edge", {7'b0, four_wire_sel}, 8'h01);
      rd(8'h7F, d);
      check("R6 status locked", d, 8'h01);
      rd(8'h2E, d);
      check("R6 other address reads zero", d, 8'h00);
   endtask

   task automatic t_sticky();
      logic [7:0] d;
      pulse(); pulse(); pulse(); pulse();
      check("R4 stays locked after more pulses", {7'b0, four_wire_sel}, 8'h01);
      wr(8'h7F); wr(8'h00);
      check("R7 write keeps lock", {7'b0, four_wire_sel}, 8'h01);
      rd(8'h7F, d);
      check("R7 status after write", d, 8'h01);
      soft_reset();
      check("R5 sw reset clears read data", reg_rd_data, 8'h00);
      check("R5 sw reset keeps lock", {7'b0, four_wire_sel}, 8'h01);
      cs_n_pin = 1'b0; cycles(40);
      check("R4 locked with pin held low", {7'b0, four_wire_sel}, 8'h01);
      cs_n_pin = 1'b1; cycles(5);
   endtask

   task automatic t_sw_partial();
      do_por();
      pulse(); pulse();
      soft_reset();
      check("R5 partial count no lock yet", {7'b0, four_wire_sel}, 8'h00);
      pulse();
      check("R5 count survives sw reset", {7'b0, four_wire_sel}, 8'h01);
   endtask

   task automatic t_write_partial();
      do_por();
      pulse();
      wr(8'h7F); wr(8'h7F);
      pulse();
      check("R7 writes leave count, two pulses", {7'b0, four_wire_sel}, 8'h00);
      pulse();
      check("R7 writes leave count, third locks", {7'b0, four_wire_sel}, 8'h01);
   endtask

   task automatic t_por_clears();
      logic [7:0] d;
      do_por();
      check("R8 power-on clears lock", {7'b0, four_wire_sel}, 8'h00);
      rd(8'h7F, d);
      check("R8 status cleared", d, 8'h00);
      pulse(); pulse();
      check("R8 needs fresh pulses", {7'b0, four_wire_sel}, 8'h00);
      pulse();
      check("R8 relocks after three", {7'b0, four_wire_sel}, 8'h01);
   endtask

   initial begin
      t_reset();
      t_static();
      t_lock_timing();
      t_sticky();
      t_sw_partial();
      t_write_partial();
      t_por_clears();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1..R8 run actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule